// File: doc/BRIEF.md
# Serial Management Frame Master

This block is the master side of an IEEE 802.3 clause-22 management link. It derives a management clock (`mdc`) from the system clock through a programmable divider. It also serialises a 32-bit management frame onto a data line that can be driven or released (`mdio_o` / `mdio_oe`, with `mdio_i` as the returned level). Software first programs the control register. The divider field sits in bits 6..1 and the preamble-skip flag in bit 7. Software then writes the frame word, and that write starts a transaction. When the frame word holds a read opcode, the block samples the reply into the low 16 bits of the frame register. A completion flag tells software when it may write the frame register again. The running divider counter is brought out for test observation.

Two state machines make up the block. The clock machine has the states CK_OFF, CK_LOW and CK_HIGH:
- CK_OFF → CK_LOW when the divider field becomes non-zero.
- CK_LOW → CK_HIGH when the counter wraps and the field is non-zero.
- CK_HIGH → CK_LOW when the counter wraps.
- CK_LOW → CK_OFF and CK_HIGH → CK_OFF when the counter wraps and the field is zero.

The frame machine has the states ST_IDLE, ST_ARM, ST_PREAMBLE, ST_SHIFT and ST_FINISH:
- ST_IDLE → ST_ARM on a frame write.
- ST_ARM → ST_PREAMBLE, or ST_ARM → ST_SHIFT when the preamble is skipped, on a falling `mdc`.
- ST_PREAMBLE → ST_SHIFT after 32 bits.
- ST_SHIFT → ST_FINISH on the falling edge that ends bit 0.
- ST_FINISH → ST_IDLE unconditionally.

Top module: `mdio_mgmt_master`

## Requirements
- R1: With divider value N (N > 0), `mdc` is high for N system clocks and low for N system clocks, giving a period of 2N.
- R2: While the divider value is zero, `mdc` stays low and `div_count` reads 0. A frame written in this condition is held and does not start until the divider becomes non-zero.
- R3: A new divider value takes effect only at the next `mdc` edge. The phase already in progress keeps its old length, and the following phases use the new one.
- R4: With control bit 7 clear, 32 ones are sent before the frame. With bit 7 set, the first bit sent is frame bit 31.
- R5: Frame bits are sent most significant first, one bit per `mdc` period, and `mdio_o` changes only when `mdc` falls.
- R6: When frame bits 29..28 equal 2'b10 (read), `mdio_oe` is low from bit 17 onward. Bits 15..0 of the frame register take `mdio_i` at the rising `mdc` edge inside each data bit.
- R7: `xfer_done` rises one system clock after the falling `mdc` edge that ends bit 0. At that point `mdio_oe` is already low. A pulse on `done_clr` clears the flag.
- R8: A frame write during a transfer replaces the frame register, and the bits not yet sent come from the new value.
- R9: The control register reads back bits 7..1 as written. All other bits read zero, and the reset value is zero.
- R10: `div_count` shows the divider counter, which runs 0..N-1 in each `mdc` phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control write data (bit 7 skip preamble, bits 6..1 divider) |
| ctrl_rdata | output | 32 | Control register read value |
| frame_we | input | 1 | Frame register write strobe; starts a transfer when idle |
| frame_wdata | input | 32 | Frame word |
| frame_rdata | output | 32 | Frame register, including sampled read data |
| done_clr | input | 1 | Write-one clear of the completion flag |
| xfer_done | output | 1 | Completion flag / interrupt |
| div_count | output | 6 | Divider counter observation |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Data line level seen at the pin |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line drive enable |

## Verification
The frame path is tried with several stimuli:
- A write frame that includes the preamble checks the 32 leading ones and MSB-first order.
- A read frame without preamble checks the release from turnaround onward and the sampling of a non-symmetric data pattern.
- A second write frame, rewritten halfway through, shows that the tail of the sent bits follows the new word.

The clock path is also exercised. The divider is measured at a fixed value, changed mid-phase to separate the old phase length from the new one, and set to zero to check that the line stops low while an armed frame waits.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;

    typedef enum logic [1:0] {
        CK_OFF  = 2'b00,
        CK_LOW  = 2'b01,
        CK_HIGH = 2'b10
    } clk_state_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_PREAMBLE,
        ST_SHIFT,
        ST_FINISH
    } mgmt_state_t;

    localparam logic [1:0] OP_READ = 2'b10;

endpackage

// File: rtl/mdio_ctrl_reg.sv
`timescale 1ns/1ps
module mdio_ctrl_reg #(
    parameter int DIV_W = 6,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [DIV_W-1:0] speed,
    output logic             skip_pre,
    output logic [REG_W-1:0] rdata
);
    localparam int SPEED_LSB = 1;
    localparam int SKIP_BIT  = SPEED_LSB + DIV_W;

    logic reserved_unused;
    assign reserved_unused = ^{wdata[REG_W-1:SKIP_BIT+1], wdata[0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            speed    <= '0;
            skip_pre <= 1'b0;
        end else if (we) begin
            speed    <= wdata[SKIP_BIT-1:SPEED_LSB];
            skip_pre <= wdata[SKIP_BIT];
        end
    end

    always_comb begin
        rdata                          = '0;
        rdata[SKIP_BIT-1:SPEED_LSB]    = speed;
        rdata[SKIP_BIT]                = skip_pre;
    end

    // R9: without a write the read value never moves
    a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(rdata));

endmodule

// File: rtl/mdc_divider.sv
`timescale 1ns/1ps
module mdc_divider
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] speed,
    output logic             mdc,
    output logic             rise_p,
    output logic             fall_p,
    output logic [DIV_W-1:0] count
);
    clk_state_t       cstate, cstate_n;
    logic [DIV_W-1:0] period, period_n, count_n;
    logic             wrap;

    assign wrap = (count == period - 1'b1);

    always_comb begin
        cstate_n = cstate;
        period_n = period;
        count_n  = count + 1'b1;
        unique case (cstate)
            CK_OFF: begin
                count_n  = '0;
                period_n = speed;
                if (speed != '0) cstate_n = CK_LOW;
            end
            CK_LOW: begin
                if (wrap) begin
                    count_n  = '0;
                    period_n = speed;
                    cstate_n = (speed == '0) ? CK_OFF : CK_HIGH;
                end
            end
            CK_HIGH: begin
                if (wrap) begin
                    count_n  = '0;
                    period_n = speed;
                    cstate_n = (speed == '0) ? CK_OFF : CK_LOW;
                end
            end
            default: begin
                count_n  = '0;
                cstate_n = CK_OFF;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cstate <= CK_OFF;
            period <= '0;
            count  <= '0;
        end else begin
            cstate <= cstate_n;
            period <= period_n;
            count  <= count_n;
        end
    end

    always_comb begin
        mdc    = cstate[1];
        rise_p = (cstate == CK_LOW) && wrap && (speed != '0);
        fall_p = (cstate == CK_HIGH) && wrap;
    end

    // R1: mdc moves only when the phase counter restarts
    a_r1_edge_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdc) |-> (count == '0));

    // R2: a zero divider never lets a low clock go high
    a_r2_zero_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(speed) == '0 && !$past(mdc)) |-> !mdc);

endmodule

// File: rtl/mdio_frame_fsm.sv
`timescale 1ns/1ps
module mdio_frame_fsm
    import mdio_mgmt_pkg::*;
#(
    parameter int FRAME_W = 32,
    parameter int PRE_LEN = 32,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rise_p,
    input  logic               fall_p,
    input  logic               skip_pre,
    input  logic               frame_we,
    input  logic [FRAME_W-1:0] frame_wdata,
    input  logic               done_clr,
    input  logic               mdio_i,
    output logic [FRAME_W-1:0] frame_q,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               xfer_done
);
    localparam int IDX_W = $clog2((PRE_LEN > FRAME_W) ? PRE_LEN : FRAME_W);
    localparam logic [IDX_W-1:0] FRAME_TOP = IDX_W'(FRAME_W - 1);
    localparam logic [IDX_W-1:0] PRE_TOP   = IDX_W'(PRE_LEN - 1);
    localparam logic [IDX_W-1:0] TA_IDX    = IDX_W'(DATA_W + 1);
    localparam logic [IDX_W-1:0] DATA_TOP  = IDX_W'(DATA_W - 1);

    mgmt_state_t      state, state_n;
    logic [IDX_W-1:0] idx, idx_n;
    logic             is_read;

    assign is_read = (frame_q[FRAME_W-3 -: 2] == OP_READ);

    always_comb begin
        state_n = state;
        idx_n   = idx;
        unique case (state)
            ST_IDLE: begin
                if (frame_we) state_n = ST_ARM;
            end
            ST_ARM: begin
                if (fall_p) begin
                    state_n = skip_pre ? ST_SHIFT : ST_PREAMBLE;
                    idx_n   = skip_pre ? FRAME_TOP : PRE_TOP;
                end
            end
            ST_PREAMBLE: begin
                if (fall_p) begin
                    if (idx == '0) begin
                        state_n = ST_SHIFT;
                        idx_n   = FRAME_TOP;
                    end else begin
                        idx_n = idx - 1'b1;
                    end
                end
            end
            ST_SHIFT: begin
                if (fall_p) begin
                    if (idx == '0) state_n = ST_FINISH;
                    else           idx_n   = idx - 1'b1;
                end
            end
            ST_FINISH: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_n;
            idx   <= idx_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdio_o    <= 1'b1;
            mdio_oe   <= 1'b0;
            xfer_done <= 1'b0;
            frame_q   <= '0;
        end else begin
            if (fall_p) begin
                unique case (state_n)
                    ST_PREAMBLE: begin
                        mdio_o  <= 1'b1;
                        mdio_oe <= 1'b1;
                    end
                    ST_SHIFT: begin
                        mdio_o  <= frame_q[idx_n];
                        mdio_oe <= !(is_read && (idx_n <= TA_IDX));
                    end
                    ST_FINISH: begin
                        mdio_o  <= 1'b1;
                        mdio_oe <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (state == ST_FINISH)  xfer_done <= 1'b1;
            else if (done_clr)       xfer_done <= 1'b0;
            if (frame_we) begin
                frame_q <= frame_wdata;
            end else if (rise_p && state == ST_SHIFT && is_read && idx <= DATA_TOP) begin
                frame_q[idx] <= mdio_i;
            end
        end
    end

    // R4: the line carries only ones during the preamble
    a_r4_preamble_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PREAMBLE && mdio_oe) |-> mdio_o);

    // R7: completion appears with the line released and the machine idle
    a_r7_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_done) |-> (!mdio_oe && state == ST_IDLE));

endmodule

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
module mdio_mgmt_master #(
    parameter int DIV_W   = 6,
    parameter int REG_W   = 32,
    parameter int FRAME_W = 32,
    parameter int PRE_LEN = 32,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_we,
    input  logic [REG_W-1:0]   ctrl_wdata,
    output logic [REG_W-1:0]   ctrl_rdata,
    input  logic               frame_we,
    input  logic [FRAME_W-1:0] frame_wdata,
    output logic [FRAME_W-1:0] frame_rdata,
    input  logic               done_clr,
    output logic               xfer_done,
    output logic [DIV_W-1:0]   div_count,
    output logic               mdc,
    input  logic               mdio_i,
    output logic               mdio_o,
    output logic               mdio_oe
);
    logic [DIV_W-1:0] speed;
    logic             skip_pre;
    logic             rise_p, fall_p;

    mdio_ctrl_reg #(.DIV_W(DIV_W), .REG_W(REG_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ctrl_we),
        .wdata    (ctrl_wdata),
        .speed    (speed),
        .skip_pre (skip_pre),
        .rdata    (ctrl_rdata)
    );

    mdc_divider #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .speed  (speed),
        .mdc    (mdc),
        .rise_p (rise_p),
        .fall_p (fall_p),
        .count  (div_count)
    );

    mdio_frame_fsm #(.FRAME_W(FRAME_W), .PRE_LEN(PRE_LEN), .DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_p      (rise_p),
        .fall_p      (fall_p),
        .skip_pre    (skip_pre),
        .frame_we    (frame_we),
        .frame_wdata (frame_wdata),
        .done_clr    (done_clr),
        .mdio_i      (mdio_i),
        .frame_q     (frame_rdata),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .xfer_done   (xfer_done)
    );

    // R5: a driven data bit changes only together with a falling clock
    a_r5_mdio_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $fell(mdc));

endmodule

// File: tb/mdio_mgmt_master_test.sv
`timescale 1ns/1ps
module mdio_mgmt_master_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctrl_we, frame_we, done_clr, mdio_i;
    logic [31:0] ctrl_wdata, ctrl_rdata, frame_wdata, frame_rdata;
    logic        xfer_done, mdc, mdio_o, mdio_oe;
    logic [5:0]  div_count;

    always #2.5 clk = ~clk;

    mdio_mgmt_master uut (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .frame_we(frame_we), .frame_wdata(frame_wdata), .frame_rdata(frame_rdata),
        .done_clr(done_clr), .xfer_done(xfer_done), .div_count(div_count),
        .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_speed, m_act, m_cnt, m_phase, m_bit, oldph;
    bit          m_skip, m_mdc, m_out, m_oe, m_done, fp, rp, rd;
    logic [31:0] m_frame;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_speed = 0; m_act = 0; m_cnt = 0; m_skip = 0; m_mdc = 0;
            m_phase = 0; m_bit = 0; m_out = 1; m_oe = 0; m_done = 0; m_frame = '0;
        end else begin
            fp = 0; rp = 0; oldph = m_phase;
            if (m_act == 0) begin
                m_mdc = 0; m_cnt = 0; m_act = m_speed;
            end else if (m_cnt == m_act - 1) begin
                m_cnt = 0;
                if (m_mdc) begin m_mdc = 0; fp = 1; m_act = m_speed; end
                else if (m_speed == 0) m_act = 0;
                else begin m_mdc = 1; rp = 1; m_act = m_speed; end
            end else begin
                m_cnt++;
            end
            rd = (m_frame[29:28] == 2'b10);
            case (m_phase)
                0: if (frame_we) m_phase = 1;
                1: if (fp) begin
                       m_bit = 31; m_oe = 1;
                       if (m_skip) begin m_phase = 3; m_out = m_frame[31]; end
                       else begin m_phase = 2; m_out = 1; end
                   end
                2: if (fp) begin
                       if (m_bit == 0) begin m_phase = 3; m_bit = 31; m_out = m_frame[31]; end
                       else m_bit--;
                   end
                3: begin
                       if (rp && rd && m_bit <= 15) m_frame[m_bit] = mdio_i;
                       if (fp) begin
                           if (m_bit == 0) begin m_phase = 4; m_oe = 0; m_out = 1; end
                           else begin
                               m_bit--;
                               m_out = m_frame[m_bit];
                               m_oe  = !(rd && m_bit <= 17);
                           end
                       end
                   end
                default: m_phase = 0;
            endcase
            if (oldph == 4) m_done = 1;
            else if (done_clr) m_done = 0;
            if (frame_we) m_frame = frame_wdata;
            if (ctrl_we) begin m_speed = int'(ctrl_wdata[6:1]); m_skip = ctrl_wdata[7]; end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(mdc === m_mdc, "R1/R2/R3 mdc vs model", {31'd0, mdc}, {31'd0, m_mdc});
            check(div_count === 6'(m_cnt), "R10 div_count vs model", {26'd0, div_count}, 32'(m_cnt));
            check(mdio_oe === m_oe, "R6/R7 mdio_oe vs model", {31'd0, mdio_oe}, {31'd0, m_oe});
            if (m_oe) check(mdio_o === m_out, "R4/R5/R8 mdio_o vs model", {31'd0, mdio_o}, {31'd0, m_out});
            check(xfer_done === m_done, "R7 xfer_done vs model", {31'd0, xfer_done}, {31'd0, m_done});
            check(frame_rdata === m_frame, "R6/R8 frame_rdata vs model", frame_rdata, m_frame);
        end
    end

    // ---------------- PHY stand-in and bit recorder ----------------
    logic [15:0] phy_word = 16'h3C96;
    always @(negedge clk) mdio_i <= (m_phase == 3 && m_bit <= 15) ? phy_word[m_bit] : 1'b1;

    logic [63:0] sent;
    int          nsent;
    logic        mdc_d = 1'b0;
    always @(negedge clk) begin
        if (mdc_d && !mdc && mdio_oe) begin
            sent  <= {sent[62:0], mdio_o};
            nsent <= nsent + 1;
        end
        mdc_d <= mdc;
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr_ctrl(input logic [31:0] v);
        @(negedge clk); ctrl_wdata = v; ctrl_we = 1'b1;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic wr_frame(input logic [31:0] v);
        @(negedge clk); frame_wdata = v; frame_we = 1'b1;
        @(negedge clk); frame_we = 1'b0;
    endtask

    task automatic clr_done();
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
    endtask

    task automatic wait_done(input string req);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (xfer_done) break;
        end
        check(xfer_done === 1'b1, req, {31'd0, xfer_done}, 32'd1);
    endtask

    task automatic wait_rise();
        logic p;
        p = mdc;
        @(negedge clk);
        while (!(!p && mdc)) begin p = mdc; @(negedge clk); end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=0", 1);
            finish_run();
        end
    end

    localparam logic [31:0] WR  = {2'b01, 2'b01, 5'd3, 5'd5, 2'b10, 16'hA5C3};
    localparam logic [31:0] RD  = {2'b01, 2'b10, 5'd1, 5'd2, 2'b11, 16'h0000};
    localparam logic [31:0] W1  = {2'b01, 2'b01, 5'd7, 5'd9, 2'b10, 16'h1234};
    localparam logic [31:0] W2  = {2'b01, 2'b01, 5'd7, 5'd9, 2'b10, 16'hFEDC};

    initial begin
        int hi, lo, mx;
        rst_n = 1'b0; ctrl_we = 0; frame_we = 0; done_clr = 0;
        ctrl_wdata = '0; frame_wdata = '0; sent = '0; nsent = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mdc === 1'b0 && mdio_oe === 1'b0 && xfer_done === 1'b0, "R7 reset idle outputs",
              {29'd0, mdc, mdio_oe, xfer_done}, 32'd0);
        check(ctrl_rdata === 32'd0, "R9 control reset value", ctrl_rdata, 32'd0);

        // R9: reserved bits read zero
        wr_ctrl(32'hFFFF_FFFF);
        check(ctrl_rdata === 32'h0000_00FE, "R9 reserved bits zero", ctrl_rdata, 32'h0000_00FE);
        wr_ctrl(32'h0);
        repeat (80) @(negedge clk);

        // R2: frame armed with divider zero does not start
        wr_frame(WR);
        hi = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (mdc !== 1'b0 || mdio_oe !== 1'b0 || div_count !== 6'd0) hi++;
        end
        check(hi == 0, "R2 clock off, frame held", 32'(hi), 32'd0);

        // R4/R5: enable divider 2 with preamble; held frame starts
        @(negedge clk); sent = '0; nsent = 0;
        wr_ctrl(32'(2 << 1));
        wait_done("R7 completion after write frame");
        check(sent === {32'hFFFF_FFFF, WR}, "R4/R5 preamble and MSB-first bits", sent[31:0], WR);
        check(nsent == 64, "R4 bit count with preamble", 32'(nsent), 32'd64);
        check(mdio_oe === 1'b0, "R7 line released at completion", {31'd0, mdio_oe}, 32'd0);
        clr_done();
        @(negedge clk);
        check(xfer_done === 1'b0, "R7 write-one clear", {31'd0, xfer_done}, 32'd0);

        // R1/R10: divider 3 gives 3 high, 3 low, counter up to 2
        wr_ctrl(32'(3 << 1));
        wait_rise(); wait_rise();
        hi = 0; lo = 0; mx = 0;
        while (mdc) begin hi++; if (int'(div_count) > mx) mx = int'(div_count); @(negedge clk); end
        while (!mdc) begin lo++; if (int'(div_count) > mx) mx = int'(div_count); @(negedge clk); end
        check(hi == 3, "R1 high phase length", 32'(hi), 32'd3);
        check(lo == 3, "R1 low phase length", 32'(lo), 32'd3);
        check(mx == 2, "R10 counter maximum", 32'(mx), 32'd2);

        // R3: change 4 -> 1 in mid high phase
        wr_ctrl(32'(4 << 1));
        wait_rise(); wait_rise();
        hi = 1;
        @(negedge clk); if (mdc) hi++;
        ctrl_wdata = 32'(1 << 1); ctrl_we = 1'b1;
        @(negedge clk); ctrl_we = 1'b0; if (mdc) hi++;
        while (mdc) begin @(negedge clk); if (mdc) hi++; end
        lo = 0;
        while (!mdc) begin lo++; @(negedge clk); end
        check(hi == 4, "R3 running phase keeps old length", 32'(hi), 32'd4);
        check(lo == 1, "R3 next phase uses new length", 32'(lo), 32'd1);

        // R6: read frame, no preamble, divider 1
        wr_ctrl(32'h80 | 32'(1 << 1));
        @(negedge clk); sent = '0; nsent = 0;
        wr_frame(RD);
        wait_done("R7 completion after read frame");
        check(frame_rdata[15:0] === phy_word, "R6 sampled read data", {16'd0, frame_rdata[15:0]}, {16'd0, phy_word});
        check(nsent == 14, "R6 driven bits before release", 32'(nsent), 32'd14);
        check(sent[13:0] === RD[31:18], "R4/R6 no preamble, header bits", {18'd0, sent[13:0]}, {18'd0, RD[31:18]});
        clr_done();

        // R8: rewrite mid-transfer
        wr_ctrl(32'h80 | 32'(2 << 1));
        @(negedge clk); sent = '0; nsent = 0;
        wr_frame(W1);
        repeat (60) @(negedge clk);
        wr_frame(W2);
        wait_done("R7 completion after rewritten frame");
        check(sent[7:0] === W2[7:0], "R8 tail bits follow new word", {24'd0, sent[7:0]}, {24'd0, W2[7:0]});
        check(sent[31:16] === W1[31:16], "R8 header bits sent", {16'd0, sent[31:16]}, {16'd0, W1[31:16]});
        clr_done();

        // R2: divider back to zero stops clock low
        wr_ctrl(32'h0);
        repeat (20) @(negedge clk);
        check(mdc === 1'b0 && div_count === 6'd0, "R2 clock stopped low", {25'd0, div_count, mdc}, 32'd0);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule